// File: doc/BRIEF.md
# Sampling Rate Classifier

This block finds out which of three common audio sampling rates a recovered frame clock runs at. It does this by timing the clock, not by decoding any rate field from the stream. The block counts cycles of a fixed 24.576 MHz reference clock over eight frame periods. It then compares that count against three count windows and reports a 2-bit code: 32 kHz, 44.1 kHz, 48 kHz, or "none of these".

The frame clock is asynchronous to the reference. It passes through a two-flop synchronizer, and only its rising edges are used. Measurement runs back to back: the edge that closes one window opens the next.

Three conditions override the measurement:
- A lock flag from the clock-recovery logic. While it is low, the result is "none".
- A reference-present flag. While it is low, the last result is frozen and any partial measurement is discarded.
- A timeout for a frame clock that has stopped.

Because the reference is the time base, any error in the reference frequency moves every window by the same proportion.

Top module: `srate_classifier`

## Requirements
- R1: After reset `rate_code` is 2'b00. It stays 2'b00 until a window completes or lock is lost while the reference is present. With `ref_present` low since reset it stays 2'b00 whatever the frame clock and lock do.
- R2: A completed window of 5994 to 6302 reference cycles (eight frame periods, about 31.2 to 32.8 kHz) gives `rate_code` 2'b11.
- R3: A completed window of 4349 to 4573 cycles (about 43.0 to 45.2 kHz) gives 2'b00.
- R4: A completed window of 3996 to 4202 cycles (about 46.8 to 49.2 kHz) gives 2'b01.
- R5: A completed window with any other count gives 2'b10.
- R6: With `ref_present` high and `locked` low, `rate_code` is 2'b10 from the next cycle on. After lock returns, the first frame rising edge starts a fresh window, and the code stays 2'b10 until that window completes.
- R7: While `ref_present` is low, `rate_code` holds its value and the partial window is dropped. After it returns, the first frame rising edge starts a fresh window.
- R8: If a started window reaches 6303 reference cycles, `rate_code` becomes 2'b10. The next frame rising edge starts a fresh window.
- R9: The frame edge that completes a window also starts the next one, so consecutive windows cover consecutive frame periods with no gap.
- R10: Priority when events meet in one cycle: reference absent first, then loss of lock, then window completion. A completion that coincides with a one-cycle drop of `locked` yields 2'b10. A completion that coincides with a one-cycle drop of `ref_present` leaves the code unchanged.
- R11: Each frame rising edge is acted on exactly once, in the cycle after the second reference edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 24.576 MHz reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Recovered frame clock, asynchronous to clk_ref |
| locked | input | 1 | High while clock recovery is locked (clk_ref domain) |
| ref_present | input | 1 | High while the reference clock is running |
| rate_code | output | 2 | 11 = 32 kHz, 00 = 44.1 kHz, 01 = 48 kHz, 10 = out of range or unlocked |

## Verification
Window completion can land in the same reference cycle as a drop of `locked` or of `ref_present`. The override must win in that cycle. The bench provokes this by driving a one-cycle low pulse on the flag exactly two reference edges after the closing frame edge, which is the cycle in which that edge is acted on. It then samples the code a few cycles later. Because the pulse lasts a single cycle, a design that let the completion win would keep the new band code, and the check against 2'b10, or against the unchanged prior code, separates the two orders.

// File: rtl/srate_pkg.sv
package srate_pkg;

    typedef enum logic [1:0] {
        RATE_44K1 = 2'b00,
        RATE_48K  = 2'b01,
        RATE_NONE = 2'b10,
        RATE_32K  = 2'b11
    } rate_code_e;

    localparam int BAND_N = 3;
    // Band edges in Hz: 32 kHz, 44.1 kHz, 48 kHz windows
    localparam int unsigned BAND_FMIN [BAND_N] = '{31200, 43000, 46800};
    localparam int unsigned BAND_FMAX [BAND_N] = '{32800, 45200, 49200};
    localparam rate_code_e  BAND_CODE [BAND_N] = '{RATE_32K, RATE_44K1, RATE_48K};

    // Lowest count in a band: highest frequency, rounded down
    function automatic int unsigned cnt_floor(longint unsigned ref_hz, int unsigned frames,
                                              int unsigned f_hz);
        return int'((ref_hz * frames) / f_hz);
    endfunction

    // Highest count in a band: lowest frequency, rounded up
    function automatic int unsigned cnt_ceil(longint unsigned ref_hz, int unsigned frames,
                                             int unsigned f_hz);
        return int'((ref_hz * frames + f_hz - 1) / f_hz);
    endfunction

    function automatic int unsigned lowest_fmin();
        int unsigned m;
        m = BAND_FMIN[0];
        for (int i = 1; i < BAND_N; i++)
            if (BAND_FMIN[i] < m) m = BAND_FMIN[i];
        return m;
    endfunction

endpackage

// File: rtl/srate_edge_sync.sv
module srate_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R11
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/srate_band_match.sv
module srate_band_match
    import srate_pkg::*;
#(
    parameter longint unsigned REF_HZ = 24576000,
    parameter int unsigned     FRAMES = 8,
    parameter int              CNT_W  = 13
) (
    input  logic [CNT_W-1:0] count_i,
    output rate_code_e       code_o
);
    logic [BAND_N-1:0] hit;

    for (genvar b = 0; b < BAND_N; b++) begin : g_band
        localparam logic [CNT_W-1:0] LO = CNT_W'(cnt_floor(REF_HZ, FRAMES, BAND_FMAX[b]));
        localparam logic [CNT_W-1:0] HI = CNT_W'(cnt_ceil(REF_HZ, FRAMES, BAND_FMIN[b]));
        assign hit[b] = (count_i >= LO) && (count_i <= HI);
    end

    always_comb begin
        code_o = RATE_NONE;
        for (int b = 0; b < BAND_N; b++)
            if (hit[b]) code_o = BAND_CODE[b];
    end

    // R5: bands never overlap, so one count names at most one rate
    always_comb begin
        if (!$isunknown(count_i))
            bands_disjoint_chk: assert ($onehot0(hit));
    end

endmodule

// File: rtl/srate_classifier.sv
module srate_classifier
    import srate_pkg::*;
#(
    parameter longint unsigned REF_HZ      = 24576000,
    parameter int unsigned     FRAMES      = 8,
    parameter int              SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       locked,
    input  logic       ref_present,
    output logic [1:0] rate_code
);
    localparam int unsigned LIMIT = cnt_ceil(REF_HZ, FRAMES, lowest_fmin()) + 1;
    localparam int          CNT_W = $clog2(LIMIT + 1);
    localparam int          FR_W  = $clog2(FRAMES + 1);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [FR_W-1:0]  FR_LAST = FR_W'(FRAMES - 1);

    typedef struct packed {
        logic             armed;
        logic [FR_W-1:0]  frames;
        logic [CNT_W-1:0] cnt;
        rate_code_e       code;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic       rise;
    rate_code_e band_code;

    srate_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .async_i(frame_clk),
        .rise_o (rise)
    );

    srate_band_match #(.REF_HZ(REF_HZ), .FRAMES(FRAMES), .CNT_W(CNT_W)) u_match (
        .count_i(ctl_q.cnt),
        .code_o (band_code)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!ref_present) begin
            // freeze result, drop partial window
            ctl_d.armed  = 1'b0;
            ctl_d.frames = '0;
            ctl_d.cnt    = '0;
        end else if (!locked) begin
            ctl_d.armed  = 1'b0;
            ctl_d.frames = '0;
            ctl_d.cnt    = '0;
            ctl_d.code   = RATE_NONE;
        end else if (ctl_q.armed && ctl_q.cnt == LIMIT_C) begin
            // window overran every band: stalled or slow frame clock
            ctl_d.code   = RATE_NONE;
            ctl_d.armed  = rise;
            ctl_d.frames = '0;
            ctl_d.cnt    = rise ? CNT_ONE : '0;
        end else if (rise) begin
            ctl_d.armed = 1'b1;
            if (!ctl_q.armed || ctl_q.frames == FR_LAST) begin
                if (ctl_q.armed) ctl_d.code = band_code;
                ctl_d.frames = '0;
                ctl_d.cnt    = CNT_ONE;
            end else begin
                ctl_d.frames = ctl_q.frames + 1'b1;
                ctl_d.cnt    = ctl_q.cnt + 1'b1;
            end
        end else if (ctl_q.armed) begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{armed: 1'b0, frames: '0, cnt: '0, code: RATE_44K1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rate_code = ctl_q.code;

    // R6
    unlock_none_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ref_present && !locked) |=> (rate_code == 2'b10));

    // R7
    absent_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !ref_present |=> $stable(rate_code));

    // R8
    cnt_bound_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ctl_q.cnt <= LIMIT_C);

    // R6: an unlocked block holds no window open
    unlocked_idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ref_present && !locked) |=> !ctl_q.armed);

endmodule

// File: tb/srate_classifier_test.sv
module srate_classifier_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       locked = 1'b0;
    logic       ref_present = 1'b0;
    logic [1:0] rate_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    srate_classifier uut (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .locked     (locked),
        .ref_present(ref_present),
        .rate_code  (rate_code)
    );

    localparam int VEC_N = 16;
    // Eight-period window length in reference cycles, and expected code
    localparam int         VEC_CNT [VEC_N] = '{6144, 4458, 4096, 5600, 5994, 5993, 6302, 6303,
                                               4349, 4348, 4573, 4574, 3996, 3995, 4202, 4203};
    localparam logic [1:0] VEC_EXP [VEC_N] = '{2'b11, 2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10,
                                               2'b00, 2'b10, 2'b00, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10};

    task automatic check(input logic [1:0] exp, input string tag);
        n_chk++;
        if (rate_code !== exp) begin
            n_fail++;
            $display("FAIL %s: rate_code=%b expected %b", tag, rate_code, exp);
        end
    endtask

    // One frame period ending in a rising edge; skip = cycles already spent high
    task automatic period(input int len, input int skip);
        repeat (len / 2 - skip) @(negedge clk);
        frame_clk = 1'b0;
        repeat (len - len / 2) @(negedge clk);
        frame_clk = 1'b1;
    endtask

    // Eight periods totalling exactly 'total' reference cycles
    task automatic window(input int total, input int skip);
        for (int k = 0; k < 8; k++)
            period((k == 7) ? total / 8 + total % 8 : total / 8, (k == 0) ? skip : 0);
    endtask

    function automatic string band_tag(input logic [1:0] c);
        case (c)
            2'b11:   return "R2 32k band (R9 back-to-back)";
            2'b00:   return "R3 44k1 band (R9 back-to-back)";
            2'b01:   return "R4 48k band (R9 back-to-back)";
            default: return "R5 out of band (R9 back-to-back)";
        endcase
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2'b00, "R1 reset value");

        // R1: reference never present, lock and frames do nothing
        locked = 1'b1;
        frame_clk = 1'b1;
        window(4096, 0);
        repeat (8) @(negedge clk);
        check(2'b00, "R1 no reference since reset");

        // reference arrives: arm, then walk the table back to back
        ref_present = 1'b1;
        period(768, 8);
        for (int i = 0; i < VEC_N; i++) begin
            window(VEC_CNT[i], (i == 0) ? 0 : 8);
            repeat (8) @(negedge clk);
            check(VEC_EXP[i], band_tag(VEC_EXP[i]));
        end

        // R6: unlock forces out-of-range, relock restarts the window
        locked = 1'b0;
        repeat (2) @(negedge clk);
        check(2'b10, "R6 unlocked");
        locked = 1'b1;
        period(768, 16);
        for (int k = 0; k < 4; k++) period(512, 0);
        repeat (8) @(negedge clk);
        check(2'b10, "R6 partial window after relock");
        period(512, 8);
        for (int k = 0; k < 3; k++) period(512, 0);
        repeat (8) @(negedge clk);
        check(2'b01, "R6 first window after relock");

        // R7: reference absent holds the result, return restarts
        ref_present = 1'b0;
        window(6144, 8);
        repeat (8) @(negedge clk);
        check(2'b01, "R7 hold while reference absent");
        ref_present = 1'b1;
        period(768, 8);
        window(6144, 0);
        repeat (8) @(negedge clk);
        check(2'b11, "R7 fresh window after reference returns");

        // R8: frame clock stalls past the longest window
        frame_clk = 1'b0;
        repeat (6400) @(negedge clk);
        check(2'b10, "R8 timeout on stalled frame clock");
        frame_clk = 1'b1;
        window(4458, 0);
        repeat (8) @(negedge clk);
        check(2'b00, "R8 measurement after timeout");

        // R10/R11: one-cycle unlock in the cycle the closing edge is acted on
        window(4096, 8);
        repeat (2) @(negedge clk);
        locked = 1'b0;
        @(negedge clk);
        locked = 1'b1;
        repeat (4) @(negedge clk);
        check(2'b10, "R10 unlock beats completion");
        period(768, 7);
        window(6144, 0);
        repeat (8) @(negedge clk);
        check(2'b11, "R10 recovery window");

        // R10/R11: one-cycle reference drop in the completion cycle
        window(4096, 8);
        repeat (2) @(negedge clk);
        ref_present = 1'b0;
        @(negedge clk);
        ref_present = 1'b1;
        repeat (4) @(negedge clk);
        check(2'b11, "R10 reference loss beats completion");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule